// File: doc/BRIEF.md
# S/PDIF Sample Data Word Formatter

This block turns decoded S/PDIF subframes into the 32-bit words that a receive data register presents. Each incoming subframe carries a 24-bit audio sample, a parity-error flag, the validity, user and channel-status bits, and a two-bit preamble type. A two-bit format select chooses how these are laid out in the output word. Four mask inputs force individual status fields to zero.

Subframes arrive on a valid/ready stream, and words leave on a second valid/ready stream through a single output register. In the two aligned layouts every subframe yields one word. In the packed layout, the upper 16 bits of two consecutive samples share one word, so a word leaves only after every second subframe. Line decoding and any buffering beyond the output register belong to neighbouring blocks.

Top module: `spdif_word_fmt`

## Requirements
- R1: Synchronous active-low reset clears `out_valid` and the half-word pointer. While `out_valid` is low, `in_ready` is high.
- R2: With `cfg_fmt` = 00, the word is: audio in bits 23:0, parity error in bit 24, validity in 25, user in 26, channel status in 27, preamble type in 29:28 and zero in 31:30. The preamble type passes through as given (B = 01, M = 10, W = 11).
- R3: With `cfg_fmt` = 01, the word is: parity error in bit 0, validity in 1, user in 2, channel status in 3, preamble type in 5:4, zero in 7:6 and audio in 31:8.
- R4: With `cfg_fmt` = 10, the first accepted subframe produces no word. The second produces a word holding the first sample's bits 23:8 in word bits 15:0 and the second sample's bits 23:8 in word bits 31:16.
- R5: When `cfg_fmt` differs from its value in the previous cycle, the half-word pointer returns to the first half, so a half-word held earlier is discarded.
- R6: `cfg_fmt` = 11 gives the same word as 00.
- R7: In formats 00, 01 and 11, each mask zeroes only its own field. `cfg_mask_par` clears parity error, `cfg_mask_val` clears validity, `cfg_mask_uc` clears both user and channel status, and `cfg_mask_pre` clears the preamble type. Audio bits and the other fields are unchanged. In format 10 the masks have no effect.
- R8: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_word` stays stable and no subframe is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fmt | input | 2 | Word layout select |
| cfg_mask_par | input | 1 | Zero the parity-error field |
| cfg_mask_val | input | 1 | Zero the validity field |
| cfg_mask_uc | input | 1 | Zero the user and channel-status fields |
| cfg_mask_pre | input | 1 | Zero the preamble-type field |
| in_valid | input | 1 | Subframe present |
| in_ready | output | 1 | Subframe accepted this cycle when valid |
| in_audio | input | 24 | Audio sample |
| in_perr | input | 1 | Parity error flag |
| in_vbit | input | 1 | Validity bit |
| in_ubit | input | 1 | User bit |
| in_cbit | input | 1 | Channel-status bit |
| in_pre | input | 2 | Preamble type |
| out_valid | output | 1 | Word present |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | 32 | Formatted data word |

## Verification
The bench sweeps every mask combination under each aligned format. This exposes a mask that clears a neighbouring field, or a user/channel-status mask that clears only one of its two bits. Packed mode is checked for both the silent first half and the half order, since a swapped pointer would emit after every subframe or put the halves in reverse order. A format switch in the middle of a pair must drop the held half; a design that keeps it would pair stale audio with new audio. A stalled output must hold its word and refuse input, or a word would be lost or overwritten.

// File: rtl/spdif_wfmt_pkg.sv
// Shared widths and types for the S/PDIF word formatter.
// Assumes one subframe per accepted handshake.
package spdif_wfmt_pkg;
    localparam int SAMPLE_W = 24;
    localparam int WORD_W   = 32;
    localparam int HALF_W   = 16;
    localparam int PRE_W    = 2;

    typedef enum logic [1:0] {
        FMT_RIGHT = 2'b00,
        FMT_LEFT  = 2'b01,
        FMT_PACK  = 2'b10,
        FMT_SPARE = 2'b11
    } fmt_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] audio;
        logic                perr;
        logic                vbit;
        logic                ubit;
        logic                cbit;
        logic [PRE_W-1:0]    pre;
    } subframe_t;
endpackage

// File: rtl/spdif_wfmt_layout.sv
// Combinational layout of one subframe into an aligned word.
// Handles the right- and left-aligned layouts; the spare encoding maps to right.
// Assumes the packed layout is produced elsewhere.
module spdif_wfmt_layout
    import spdif_wfmt_pkg::*;
(
    input  logic [1:0]        fmt,
    input  logic              mask_par,
    input  logic              mask_val,
    input  logic              mask_uc,
    input  logic              mask_pre,
    input  subframe_t         sf,
    output logic [WORD_W-1:0] word
);
    localparam int STAT_W = 4 + PRE_W;
    localparam int PAD_L  = WORD_W - SAMPLE_W - STAT_W;

    logic [STAT_W-1:0] stat;

    // Apply masks and order the status bits: pre, C, U, V, parity error
    always_comb begin
        stat = {mask_pre ? {PRE_W{1'b0}} : sf.pre,
                mask_uc  ? 1'b0 : sf.cbit,
                mask_uc  ? 1'b0 : sf.ubit,
                mask_val ? 1'b0 : sf.vbit,
                mask_par ? 1'b0 : sf.perr};
    end

    // Place status and audio according to the selected alignment
    always_comb begin
        if (fmt == FMT_LEFT)
            word = {sf.audio, {PAD_L{1'b0}}, stat};
        else
            word = {{PAD_L{1'b0}}, stat, sf.audio};
    end
endmodule

// File: rtl/spdif_wfmt_packer.sv
// Half-word pointer and holding register for the packed 16-bit layout.
// The first accepted subframe is held; the second completes the word.
// A change of format since the last cycle returns the pointer to the first half.
module spdif_wfmt_packer
    import spdif_wfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        fmt,
    input  logic              acc,
    input  logic [HALF_W-1:0] sample_hi,
    output logic              emit,
    output logic [WORD_W-1:0] packed_word
);
    logic              ptr;
    logic [1:0]        fmt_q;
    logic [HALF_W-1:0] hold;
    logic              is_pack;
    logic              ptr_eff;

    // Decode packed mode and the effective pointer after a format change
    always_comb begin
        is_pack     = (fmt == FMT_PACK);
        ptr_eff     = ptr && (fmt == fmt_q);
        emit        = acc && is_pack && ptr_eff;
        packed_word = {sample_hi, hold};
    end

    // Track the format, advance the pointer and capture the first half
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr   <= 1'b0;
            fmt_q <= FMT_RIGHT;
            hold  <= '0;
        end else begin
            fmt_q <= fmt;
            if (acc && is_pack) begin
                ptr <= !ptr_eff;
                if (!ptr_eff)
                    hold <= sample_hi;
            end else if (fmt != fmt_q) begin
                ptr <= 1'b0;
            end
        end
    end

    // R4
    pack_first_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && is_pack && !ptr_eff) |=> ptr);

    // R5
    fmt_change_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fmt != fmt_q) && !(acc && is_pack)) |=> !ptr);
endmodule

// File: rtl/spdif_word_fmt.sv
// S/PDIF sample data word formatter, top level.
// Accepts subframes on a valid/ready stream and emits 32-bit words from one
// output register. Assumes configuration inputs are steady around each subframe.
module spdif_word_fmt
    import spdif_wfmt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cfg_fmt,
    input  logic                cfg_mask_par,
    input  logic                cfg_mask_val,
    input  logic                cfg_mask_uc,
    input  logic                cfg_mask_pre,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_audio,
    input  logic                in_perr,
    input  logic                in_vbit,
    input  logic                in_ubit,
    input  logic                in_cbit,
    input  logic [PRE_W-1:0]    in_pre,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [WORD_W-1:0]   out_word
);
    subframe_t         sf;
    logic              acc;
    logic              emit;
    logic              load;
    logic [WORD_W-1:0] aligned_word;
    logic [WORD_W-1:0] packed_word;

    // Gather the subframe and derive the handshake
    always_comb begin
        sf       = '{audio: in_audio, perr: in_perr, vbit: in_vbit,
                     ubit: in_ubit, cbit: in_cbit, pre: in_pre};
        in_ready = !out_valid || out_ready;
        acc      = in_valid && in_ready;
        load     = acc && ((cfg_fmt != FMT_PACK) || emit);
    end

    spdif_wfmt_layout u_layout (
        .fmt      (cfg_fmt),
        .mask_par (cfg_mask_par),
        .mask_val (cfg_mask_val),
        .mask_uc  (cfg_mask_uc),
        .mask_pre (cfg_mask_pre),
        .sf       (sf),
        .word     (aligned_word)
    );

    spdif_wfmt_packer u_packer (
        .clk         (clk),
        .rst_n       (rst_n),
        .fmt         (cfg_fmt),
        .acc         (acc),
        .sample_hi   (in_audio[SAMPLE_W-1 -: HALF_W]),
        .emit        (emit),
        .packed_word (packed_word)
    );

    // Output register: load a finished word, drop valid once taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_word  <= (cfg_fmt == FMT_PACK) ? packed_word : aligned_word;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

    // R7
    mask_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (cfg_fmt == FMT_RIGHT) && cfg_mask_pre) |=> (out_word[29:28] == 2'b00));

    // R6
    spare_audio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (cfg_fmt == FMT_SPARE)) |=> (out_valid && out_word[23:0] == $past(in_audio)));
endmodule

// File: tb/spdif_word_fmt_bench.sv
module spdif_word_fmt_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_fmt = 2'b00;
    logic        m_par = 1'b0, m_val = 1'b0, m_uc = 1'b0, m_pre = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] in_audio = '0;
    logic        in_perr = 1'b0, in_vbit = 1'b0, in_ubit = 1'b0, in_cbit = 1'b0;
    logic [1:0]  in_pre = 2'b00;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_word;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    spdif_word_fmt u_spdif_word_fmt (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt),
        .cfg_mask_par(m_par), .cfg_mask_val(m_val),
        .cfg_mask_uc(m_uc), .cfg_mask_pre(m_pre),
        .in_valid(in_valid), .in_ready(in_ready), .in_audio(in_audio),
        .in_perr(in_perr), .in_vbit(in_vbit), .in_ubit(in_ubit),
        .in_cbit(in_cbit), .in_pre(in_pre),
        .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [1:0] f, input logic [3:0] m,
        input logic [23:0] d, input logic p, input logic v, input logic u,
        input logic c, input logic [1:0] pt);
        logic [5:0] st;
        st = {m[3] ? 2'b00 : pt, m[2] ? 1'b0 : c, m[2] ? 1'b0 : u,
              m[1] ? 1'b0 : v, m[0] ? 1'b0 : p};
        if (f == 2'b01) return {d, 2'b00, st};
        return {2'b00, st, d};
    endfunction

    task automatic send(input logic [23:0] d, input logic [4:0] st);
        @(negedge clk);
        in_audio = d;
        {in_perr, in_vbit, in_ubit, in_cbit} = st[3:0];
        in_pre = (st[4] ? 2'b11 : 2'b01) ^ {1'b0, st[0]};
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 in_ready", {31'd0, in_ready}, 32'd1);
        rst_n = 1'b1;

        // R2 R3 R6 R7: sweep aligned formats and all mask combinations
        for (int fi = 0; fi < 3; fi++) begin
            cfg_fmt = (fi == 2) ? 2'b11 : fi[1:0];
            for (int m = 0; m < 16; m++) begin
                {m_pre, m_uc, m_val, m_par} = m[3:0];
                for (int k = 0; k < 4; k++) begin
                    logic [23:0] d;
                    logic [4:0]  st;
                    logic [1:0]  pt;
                    d  = 24'h5A3C96 ^ (24'h13579B * k[23:0]) ^ {20'd0, m[3:0]};
                    st = 5'(k * 7 + m);
                    pt = (st[4] ? 2'b11 : 2'b01) ^ {1'b0, st[0]};
                    send(d, st);
                    check(fi == 1 ? "R3 left word" : (fi == 2 ? "R6 spare word" : "R2/R7 right word"),
                          out_word, exp_word(cfg_fmt, m[3:0], d, st[3], st[2], st[1], st[0], pt));
                    check("R7 valid", {31'd0, out_valid}, 32'd1);
                end
            end
        end

        // R4 R7: packed pairs, masks must not matter
        cfg_fmt = 2'b10;
        @(negedge clk);
        for (int m = 0; m < 16; m++) begin
            logic [23:0] a, b;
            {m_pre, m_uc, m_val, m_par} = m[3:0];
            a = 24'hA1B2C3 + 24'h010203 * m[23:0];
            b = 24'h4D5E6F ^ {m[7:0], 16'h0F0F};
            send(a, 5'h1F);
            check("R4 no word after first half", {31'd0, out_valid}, 32'd0);
            send(b, 5'h0F);
            check("R4 packed valid", {31'd0, out_valid}, 32'd1);
            check("R4 packed word", out_word, {b[23:8], a[23:8]});
        end

        // R5: format change drops the held half
        {m_pre, m_uc, m_val, m_par} = 4'd0;
        send(24'h111111, 5'd0);
        @(negedge clk) cfg_fmt = 2'b00;
        @(negedge clk) cfg_fmt = 2'b10;
        send(24'h222222, 5'd0);
        check("R5 pointer cleared", {31'd0, out_valid}, 32'd0);
        send(24'h333333, 5'd0);
        check("R5 fresh pair", out_word, 32'h33332222);

        // R8: back-pressure
        cfg_fmt = 2'b00;
        @(negedge clk);
        out_ready = 1'b0;
        send(24'hABCDEF, 5'd0);
        check("R8 first word", out_word, exp_word(2'b00, 4'd0, 24'hABCDEF, 0, 0, 0, 0, 2'b01));
        in_audio = 24'h123456; in_valid = 1'b1;
        check("R8 in_ready low", {31'd0, in_ready}, 32'd0);
        @(negedge clk);
        @(negedge clk);
        check("R8 word held", out_word, exp_word(2'b00, 4'd0, 24'hABCDEF, 0, 0, 0, 0, 2'b01));
        check("R8 valid held", {31'd0, out_valid}, 32'd1);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 second word", out_word, exp_word(2'b00, 4'd0, 24'h123456, 0, 0, 0, 0, 2'b01));
        @(negedge clk);
        check("R8 drained", {31'd0, out_valid}, 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule